// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register

This block receives configuration words for a frequency synthesizer over three write-only lines: a serial data line, a serial clock and an active-low enable. While the enable line is low, each rising edge of the serial clock shifts one data bit into a 21-bit window. Only the 21 most recently shifted bits are kept. When the enable line returns high, the four trailing bits of the window are decoded as an address. A single load then copies the 17 leading bits into the latch that the address selects.

Four latches are reachable. The test latch is meant to hold zeros. The control latch supplies the lock-detect enable, the 2-bit charge pump gain code and the software power-on bit. The other two latches hold the 17-bit main divider ratio and the 11-bit reference divider ratio. Loading works whatever the power-on state is. All serial lines are sampled on the system clock through a two-stage synchronizer, and edges are detected after it. For this reason the serial clock must stay slower than about a third of the system clock rate.

Top module: `tri_wire_cfg`

## Requirements
- R1: Serial clock edges that occur while `cfg_en_n` is high shift no bit into the window and leave every output unchanged.
- R2: The window holds the last 21 bits shifted in, with the newest bit at the address end. Bursts longer than 21 bits lose their leading bits. Bursts shorter than 21 bits are not rejected: the load uses whatever the window holds at that moment.
- R3: A frame is sent most significant bit first. It carries data bits d16 down to d0, followed by address bits a3 down to a0, so a0 is the last bit of the frame.
- R4: Outputs change only on the load that follows a rising edge of `cfg_en_n`. Shifting while the enable is low changes no output.
- R5: Address 0000 loads all 17 data bits into `test_word`.
- R6: Address 0001 updates only the control fields. `lock_det_en` takes d12, `cp_gain[1]` takes d10, `cp_gain[0]` takes d9 and `soft_pwr_on` takes d6. The remaining data bits have no effect on any output.
- R7: Address 0100 loads d16..d0 into `main_ratio`, with d16 as the MSB.
- R8: Address 0101 loads d10..d0 into `ref_ratio`, with d10 as the MSB. Bits d16..d11 are ignored.
- R9: A load to any of the twelve other addresses changes no output.
- R10: After reset, every output is zero.
- R11: Loads are accepted while `soft_pwr_on` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk | input | 1 | Serial clock; data is captured on its rising edge |
| cfg_dat | input | 1 | Serial data |
| cfg_en_n | input | 1 | Active-low frame enable; its rising edge loads a latch |
| test_word | output | 17 | Test latch contents |
| lock_det_en | output | 1 | Lock-detect enable |
| cp_gain | output | 2 | Charge pump gain code |
| soft_pwr_on | output | 1 | Software power-on |
| main_ratio | output | 17 | Main divider ratio |
| ref_ratio | output | 11 | Reference divider ratio |

## Verification
Directed frames are sent to each mapped address using extreme values: all ones, alternating patterns, and filled don't-care bits. These frames separate bit-order and field-position errors from decode errors. Bursts longer than 21 bits, bursts shorter than 21 bits, and an empty burst that follows clock edges sent while the enable was high show whether the window keeps the right bits and ignores idle edges. Frames to all twelve unused addresses, plus random frames with random leading junk, confirm that only the addressed latch moves. An output snapshot taken before the enable rises shows that no latch changes early.

// File: rtl/tri_wire_cfg.sv
module tri_wire_cfg #(
  parameter int DW        = 17,
  parameter int AW        = 4,
  parameter int RW        = 11,
  parameter int SYNC      = 2,
  parameter logic [3:0] A_TEST = 4'b0000,
  parameter logic [3:0] A_CTRL = 4'b0001,
  parameter logic [3:0] A_MAIN = 4'b0100,
  parameter logic [3:0] A_REF  = 4'b0101,
  parameter int LOCK_BIT  = 12,
  parameter int GAIN_LSB  = 9,
  parameter int PON_BIT   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_clk,
  input  logic          cfg_dat,
  input  logic          cfg_en_n,
  output logic [DW-1:0] test_word,
  output logic          lock_det_en,
  output logic [1:0]    cp_gain,
  output logic          soft_pwr_on,
  output logic [DW-1:0] main_ratio,
  output logic [RW-1:0] ref_ratio
);
  localparam int FW = DW + AW;

  logic [SYNC-1:0] ck_s, dt_s, en_s;
  logic            ck_q, en_q;
  logic [FW-1:0]   win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
      en_s <= '1;
      ck_q <= 1'b0;
      en_q <= 1'b1;
    end else begin
      ck_s <= {ck_s[SYNC-2:0], cfg_clk};
      dt_s <= {dt_s[SYNC-2:0], cfg_dat};
      en_s <= {en_s[SYNC-2:0], cfg_en_n};
      ck_q <= ck_s[SYNC-1];
      en_q <= en_s[SYNC-1];
    end

  wire           shift_go = ck_s[SYNC-1] & ~ck_q & ~en_s[SYNC-1];
  wire           load_go  = en_s[SYNC-1] & ~en_q;
  wire [AW-1:0]  addr     = win[AW-1:0];
  wire [DW-1:0]  field    = win[FW-1:AW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        win <= '0;
    else if (shift_go) win <= {win[FW-2:0], dt_s[SYNC-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      test_word   <= '0;
      lock_det_en <= 1'b0;
      cp_gain     <= '0;
      soft_pwr_on <= 1'b0;
      main_ratio  <= '0;
      ref_ratio   <= '0;
    end else if (load_go) begin
      case (addr)
        A_TEST: test_word <= field;
        A_CTRL: begin
          lock_det_en <= field[LOCK_BIT];
          cp_gain     <= field[GAIN_LSB+1:GAIN_LSB];
          soft_pwr_on <= field[PON_BIT];
        end
        A_MAIN: main_ratio <= field;
        A_REF:  ref_ratio  <= field[RW-1:0];
        default: ;
      endcase
    end

  wire [DW+DW+RW+3:0] all_out = {test_word, lock_det_en, cp_gain, soft_pwr_on, main_ratio, ref_ratio};

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    en_s[SYNC-1] |=> $stable(win)); // R1

  AST_NO_EARLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_go |=> $stable(all_out)); // R4

  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && addr != A_TEST && addr != A_CTRL && addr != A_MAIN && addr != A_REF)
      |=> $stable(all_out)); // R9

  AST_MAIN_TAKES_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && addr == A_MAIN) |=> main_ratio == $past(win[FW-1:AW]) && $stable(ref_ratio)); // R7

  AST_REF_KEEPS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && addr == A_REF) |=> $stable(main_ratio) && $stable(test_word)); // R8

  AST_CTRL_PON: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && addr == A_CTRL) |=> soft_pwr_on == $past(win[AW+PON_BIT]) && $stable(main_ratio)); // R6
endmodule

// File: tb/tri_wire_cfg_tb.sv
module tri_wire_cfg_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_clk = 1'b0, cfg_dat = 1'b0, cfg_en_n = 1'b1;
  logic [16:0] test_word, main_ratio;
  logic [10:0] ref_ratio;
  logic [1:0]  cp_gain;
  logic        lock_det_en, soft_pwr_on;

  tri_wire_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat), .cfg_en_n(cfg_en_n),
    .test_word(test_word), .lock_det_en(lock_det_en), .cp_gain(cp_gain),
    .soft_pwr_on(soft_pwr_on), .main_ratio(main_ratio), .ref_ratio(ref_ratio)
  );

  always #4 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  logic [20:0] m_win = '0;
  logic [16:0] m_test = '0, m_main = '0;
  logic [10:0] m_ref = '0;
  logic [1:0]  m_cp = '0;
  logic        m_lock = 1'b0, m_pon = 1'b0;
  bit          done = 0;

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "test_word",   32'(test_word),   32'(m_test));
    chk(req, "lock_det_en", 32'(lock_det_en), 32'(m_lock));
    chk(req, "cp_gain",     32'(cp_gain),     32'(m_cp));
    chk(req, "soft_pwr_on", 32'(soft_pwr_on), 32'(m_pon));
    chk(req, "main_ratio",  32'(main_ratio),  32'(m_main));
    chk(req, "ref_ratio",   32'(ref_ratio),   32'(m_ref));
  endtask

  function automatic void model_load();
    case (m_win[3:0])
      4'b0000: m_test = m_win[20:4];
      4'b0001: begin
        m_lock = m_win[4+12];
        m_cp   = m_win[4+10:4+9];
        m_pon  = m_win[4+6];
      end
      4'b0100: m_main = m_win[20:4];
      4'b0101: m_ref  = m_win[14:4];
      default: ;
    endcase
  endfunction

  task automatic shift_bit(logic b);
    cfg_dat = b;
    cfg_clk = 1'b0;
    wclk(3);
    cfg_clk = 1'b1;
    if (!cfg_en_n) m_win = {m_win[19:0], b};
    wclk(3);
    cfg_clk = 1'b0;
  endtask

  task automatic open_burst(logic [63:0] v, int n);
    cfg_en_n = 1'b0;
    wclk(3);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    wclk(3);
  endtask

  task automatic close_burst();
    cfg_en_n = 1'b1;
    model_load();
    wclk(10);
  endtask

  task automatic burst(logic [63:0] v, int n);
    open_burst(v, n);
    close_burst();
  endtask

  task automatic frame(logic [16:0] d, logic [3:0] a);
    burst({43'd0, d, a}, 21);
  endtask

  initial begin
    wclk(3);
    check_all("R10");
    rst_n = 1'b1;
    wclk(4);
    check_all("R10");

    // R11 and R6: control load while powered down, don't-care bits set
    frame(17'b1_1111_0101_1011_1111 & ~17'b0_0000_0100_0000_0000 | 17'b0_0001_0010_0000_0000, 4'b0001);
    check_all("R6");
    frame(17'b0_0000_0000_0100_0000, 4'b0001);
    check_all("R6");
    frame(17'b1_1110_1001_1011_1111, 4'b0001);
    check_all("R11");
    frame(17'b0_0000_0000_0000_0000, 4'b0001);
    frame(17'h1_2345, 4'b0100);
    check_all("R11");

    // R7 / R3 main ratio patterns
    frame(17'h1_FFFF, 4'b0100); check_all("R7");
    frame(17'h0_AAAA, 4'b0100); check_all("R3");
    frame(17'h1_5555, 4'b0100); check_all("R3");

    // R8 reference ratio with upper bits set
    frame(17'h1_FC05, 4'b0101); check_all("R8");
    frame(17'h0_03FF, 4'b0101); check_all("R8");

    // R5 test latch
    frame(17'h0_BEEF, 4'b0000); check_all("R5");
    frame(17'h0_0000, 4'b0000); check_all("R5");

    // R9 every unmapped address
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 1 || a == 4 || a == 5) continue;
      frame(17'($urandom) | 17'h1_0001, 4'(a));
      check_all("R9");
    end

    // R2 long burst with leading junk
    burst({39'd0, 4'b1011, 17'h0_1234, 4'b0100}, 25);
    check_all("R2");
    // R2 short burst reuses the window contents
    burst(64'b0101, 4);
    check_all("R2");

    // R1 idle edges then empty burst
    frame(17'h0_4321, 4'b0100);
    for (int i = 0; i < 6; i++) shift_bit(1'b1);
    check_all("R1");
    burst(64'd0, 0);
    check_all("R1");

    // R4 no output change before enable rises
    open_burst({43'd0, 17'h1_0F0F, 4'b0100}, 21);
    check_all("R4");
    close_burst();
    check_all("R4");

    // random frames with random leading bits
    void'($urandom(32'd1234));
    for (int k = 0; k < 60; k++) begin
      logic [3:0]  a;
      logic [16:0] d;
      logic [4:0]  junk;
      int          extra;
      a = 4'($urandom);
      if ($urandom % 2 == 0) a = (a[0]) ? {a[2] ? 4'b0100 : 4'b0000} | 4'b0001 : {a[2] ? 4'b0100 : 4'b0000};
      d = 17'($urandom);
      junk = 5'($urandom);
      extra = int'($urandom % 5);
      burst({38'd0, junk, d, a} & ((64'd1 << (21 + extra)) - 64'd1), 21 + extra);
      check_all("R2");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule